// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Controller

This block wraps a single-port behavioural memory so that it follows a late-write, pipelined-read protocol. On every rising clock edge it samples a command: address, an active-low chip select, an active-low write enable and four active-low lane-write enables. A write supplies only its address and lane mask on the command edge. Its 36-bit data word is taken on the following edge.

A completed write does not go into the array straight away. It waits in a one-entry posted-write buffer. It is moved into the array only when the next write's data is accepted, and the new write takes its place in the same cycle. Reads look at the buffer first. When the read address matches the buffered address, the enabled lanes of the buffered word replace the array lanes, so a read always returns the newest data.

Read results are registered and shown one cycle later. An active-high drive flag stands in for the tri-state data pins. That flag is further gated, without reference to the clock, by an active-low output enable and by a sleep input.

Top module: `lw_sram_ctrl`

## Requirements
- R1: A read is a cycle with sel_n_i low, wr_n_i high and sleep_i low at a rising edge. Its data appears on rdata_o with rdrive_o high after the next rising edge and stays until the edge after that.
- R2: A cycle with sel_n_i high is a deselect, whatever the other command inputs are. It writes nothing, and rdrive_o is low in the result slot that follows it.
- R3: A cycle with sel_n_i low, wr_n_i low and all four lane_wr_n_i bits high is a dummy cycle. It writes nothing and leaves rdrive_o low in its result slot.
- R4: A write is a cycle with sel_n_i low, wr_n_i low and at least one lane_wr_n_i bit low. Its data is taken from wdata_i at the rising edge after the one that sampled the address.
- R5: Lane k is wdata_i/rdata_o bits [9k+8:9k]. It is written only when lane_wr_n_i bit k was low in the write command. All other lanes of that word keep their earlier contents.
- R6: A completed write is held in a one-entry buffer. It is committed to the array when the next write's data is taken. A later read of that address after it has been displaced returns the committed data.
- R7: A read of the buffered address returns the buffered lanes merged over the array word. This includes a read issued in the cycle right after the write command.
- R8: While oe_n_i is high, rdrive_o is low and rdata_o is zero, with no clock edge needed. The registered read result is unchanged and reappears when oe_n_i returns low.
- R9: While sleep_i is high, rdrive_o is low and rdata_o is zero. A command or write-data edge that falls while sleep_i is high is ignored, so a write whose data edge falls in sleep is dropped.
- R10: After reset, rdrive_o is low and the write buffer is empty, so a write still held in the buffer at reset is lost.
- R11: Back-to-back writes are all kept, both to different addresses and as partial writes to the same address whose lanes accumulate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_i | input | 1 | Sleep: blocks commands and gates the drivers |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| sel_n_i | input | 1 | Active-low chip select |
| wr_n_i | input | 1 | Active-low write enable |
| lane_wr_n_i | input | 4 | Active-low lane-write enables, bit k for lane k |
| addr_i | input | 6 | Word address |
| wdata_i | input | 36 | Write data, taken one edge after its address |
| rdata_o | output | 36 | Read data, zero when not driven |
| rdrive_o | output | 1 | High when the data outputs are driven |

## Verification
The bench first aims at the buffer's hand-over. A read issued right after its write would return stale array data if bypass were missing. A read of an address pushed out by a later write would return garbage if the commit were skipped or aimed at the wrong entry. Partial writes to one address check that the lane mask travels with the buffered word, since a design that drops the mask would clobber neighbouring lanes. Dummy cycles, deselects that carry write controls, writes whose data edge falls in sleep, and a reset taken while the buffer is full all show up as a wrong word on a later read. The asynchronous gates are toggled in mid-cycle, where a registered gate would lag by a clock.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              sel_n_i,
  input  logic              wr_n_i,
  input  logic [LANES-1:0]  lane_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output lw_op_e            op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  mask_o
);
  lw_op_e            op_d, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic              load_en;

  // decode: write needs at least one lane enabled, otherwise dummy
  always_comb begin
    op_d = OP_IDLE;
    if (!sleep_i && !sel_n_i) begin
      if (wr_n_i)                op_d = OP_READ;
      else if (~lane_n_i != '0)  op_d = OP_WRITE;
    end
    load_en = (op_d != OP_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OP_IDLE;
    else        op_q <= op_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= addr_i;
      mask_q <= ~lane_n_i;
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign mask_o = mask_q;

  // R9: no command survives a sleep edge
  a_r9_sleep_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (op_o == OP_IDLE));
  // R3: select + write with no lane is a dummy cycle
  a_r3_dummy_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !sel_n_i && !wr_n_i && (&lane_n_i)) |=> (op_o == OP_IDLE));
endmodule

// File: rtl/lw_post_buf.sv
module lw_post_buf
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_i,
  input  lw_op_e                  op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [LANES*LANE_W-1:0] arr_rdata_i,
  output logic                    cm_en_o,
  output logic [ADDR_W-1:0]       cm_addr_o,
  output logic [LANES-1:0]        cm_mask_o,
  output logic [LANES*LANE_W-1:0] cm_data_o,
  output logic [LANES*LANE_W-1:0] rd_merged_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              take;
  logic              vld_d, vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] data_q;
  logic              hit;

  // data phase of a write: the old entry leaves, the new one lands
  always_comb begin
    take  = (op_i == OP_WRITE) && !sleep_i;
    vld_d = vld_q | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q <= addr_i;
      mask_q <= mask_i;
      data_q <= wdata_i;
    end
  end

  assign cm_en_o   = take & vld_q;
  assign cm_addr_o = addr_q;
  assign cm_mask_o = mask_q;
  assign cm_data_o = data_q;

  assign hit = vld_q && (addr_q == addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign rd_merged_o[l*LANE_W +: LANE_W] = (hit && mask_q[l]) ?
      data_q[l*LANE_W +: LANE_W] : arr_rdata_i[l*LANE_W +: LANE_W];
  end

  // R6: a taken write always leaves a valid entry behind
  a_r6_entry_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> vld_q);
  // R6: a held entry keeps its address until the next write displaces it
  a_r6_entry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && vld_q) |=> ($stable(addr_q) && $stable(mask_q)));
endmodule

// File: rtl/lw_mem_array.sv
module lw_mem_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES-1:0]        wr_mask_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en_i && wr_mask_i[l])
        lane_mem[wr_addr_i] <= wr_data_i[l*LANE_W +: LANE_W];
    end

    assign rd_data_o[l*LANE_W +: LANE_W] = lane_mem[rd_addr_i];
  end

  // R5: a commit always carries at least one lane
  always_ff @(posedge clk) begin
    if (wr_en_i) a_r5_commit_has_lane: assert (wr_mask_i != '0);
  end
endmodule

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_i,
  input  logic                    oe_n_i,
  input  logic                    sel_n_i,
  input  logic                    wr_n_i,
  input  logic [LANES-1:0]        lane_wr_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdrive_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  lw_op_e            cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_mask;
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_mask;
  logic [DATA_W-1:0] cm_data;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] merged;
  logic              rd_take;
  logic              out_vld_d, out_vld_q;
  logic [DATA_W-1:0] out_data_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .sleep_i  (sleep_i),
    .sel_n_i  (sel_n_i),
    .wr_n_i   (wr_n_i),
    .lane_n_i (lane_wr_n_i),
    .addr_i   (addr_i),
    .op_o     (cmd_op),
    .addr_o   (cmd_addr),
    .mask_o   (cmd_mask)
  );

  lw_post_buf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .sleep_i     (sleep_i),
    .op_i        (cmd_op),
    .addr_i      (cmd_addr),
    .mask_i      (cmd_mask),
    .wdata_i     (wdata_i),
    .arr_rdata_i (arr_rdata),
    .cm_en_o     (cm_en),
    .cm_addr_o   (cm_addr),
    .cm_mask_o   (cm_mask),
    .cm_data_o   (cm_data),
    .rd_merged_o (merged)
  );

  lw_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk       (clk),
    .wr_en_i   (cm_en),
    .wr_addr_i (cm_addr),
    .wr_mask_i (cm_mask),
    .wr_data_i (cm_data),
    .rd_addr_i (cmd_addr),
    .rd_data_o (arr_rdata)
  );

  // output register: loads on the edge after the read command
  always_comb begin
    rd_take   = (cmd_op == OP_READ) && !sleep_i;
    out_vld_d = rd_take;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) out_vld_q <= 1'b0;
    else          out_vld_q <= out_vld_d;
  end

  always_ff @(posedge clk) begin
    if (rd_take) out_data_q <= merged;
  end

  assign rdrive_o = out_vld_q & ~oe_n_i & ~sleep_i;
  assign rdata_o  = rdrive_o ? out_data_q : '0;

  // R1: a read command drives data in the slot after the next edge
  a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!sleep_i && !sel_n_i && wr_n_i) ##1 !sleep_i |=> (rdrive_o || oe_n_i || sleep_i));
  // R2: a deselect leaves its result slot undriven
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    sel_n_i |=> ##1 !rdrive_o);
  // R9: a sleep edge leaves the following result slot undriven
  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    sleep_i |=> ##1 !rdrive_o);
endmodule

// File: tb/tb_lw_sram_ctrl.sv
`timescale 1ns/100ps
module tb_lw_sram_ctrl;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int NV = 26;

  // vector: {sleep, sel_n, wr_n, lane_n[3:0], addr[5:0], wdata[35:0]}
  localparam logic [48:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'b0000, 6'd1, 36'h000000000},  // 0  write A1
    {1'b0, 1'b1, 1'b1, 4'b1111, 6'd0, 36'h123456789},  // 1  deselect, data for A1
    {1'b0, 1'b0, 1'b0, 4'b0000, 6'd2, 36'h000000000},  // 2  write A2
    {1'b0, 1'b0, 1'b0, 4'b0000, 6'd3, 36'hABCDEF012},  // 3  write A3, data A2
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd1, 36'h0F0F0F0F0},  // 4  read A1, data A3
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd3, 36'h000000000},  // 5  read A3 from buffer
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd2, 36'h000000000},  // 6  read A2 from array
    {1'b0, 1'b0, 1'b0, 4'b1110, 6'd3, 36'h000000000},  // 7  write A3 lane 0
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd3, 36'h0000001FF},  // 8  read A3 at once
    {1'b0, 1'b0, 1'b0, 4'b0111, 6'd3, 36'h000000000},  // 9  write A3 lane 3
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd3, 36'h155000000},  // 10 read A3, lanes merged
    {1'b0, 1'b0, 1'b0, 4'b1111, 6'd3, 36'h000000000},  // 11 dummy
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd3, 36'hFFFFFFFFF},  // 12 read A3
    {1'b0, 1'b1, 1'b0, 4'b0000, 6'd2, 36'h000000000},  // 13 deselect w/ write ctl
    {1'b0, 1'b1, 1'b1, 4'b1111, 6'd0, 36'h777777777},  // 14 idle
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd2, 36'h000000000},  // 15 read A2
    {1'b1, 1'b0, 1'b0, 4'b0000, 6'd1, 36'h000000000},  // 16 write under sleep
    {1'b0, 1'b1, 1'b1, 4'b1111, 6'd0, 36'hFFFFFFFFF},  // 17 idle
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd1, 36'h000000000},  // 18 read A1
    {1'b0, 1'b0, 1'b0, 4'b0000, 6'd2, 36'h000000000},  // 19 write A2
    {1'b1, 1'b1, 1'b1, 4'b1111, 6'd0, 36'h000000005},  // 20 data edge in sleep
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd2, 36'h000000000},  // 21 read A2
    {1'b0, 1'b0, 1'b1, 4'b1111, 6'd1, 36'h000000000},  // 22 read A1
    {1'b1, 1'b1, 1'b1, 4'b1111, 6'd0, 36'h000000000},  // 23 sleep kills slot
    {1'b0, 1'b1, 1'b1, 4'b1111, 6'd0, 36'h000000000},  // 24 idle
    {1'b0, 1'b1, 1'b1, 4'b1111, 6'd0, 36'h000000000}   // 25 idle
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_i, oe_n_i, sel_n_i, wr_n_i;
  logic [NL-1:0] lane_wr_n_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          rdrive_o;

  always #2.5 clk = ~clk;

  lw_sram_ctrl #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .oe_n_i(oe_n_i),
    .sel_n_i(sel_n_i), .wr_n_i(wr_n_i), .lane_wr_n_i(lane_wr_n_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rdrive_o(rdrive_o)
  );

  int n_run = 0;
  int n_fail = 0;

  // reference model: flat memory holding the newest data per word
  logic [DW-1:0] flat [1 << AW];
  logic          pend_wr;
  logic [AW-1:0] pend_addr;
  logic [NL-1:0] pend_mask;
  logic          p1_drv, p2_drv;
  logic [DW-1:0] p1_data, p2_data;
  string         p1_tag, p2_tag;

  function automatic string vec_tag(int i);
    case (i)
      0: return "R4";   1: return "R2";   2: return "R11";  3: return "R11";
      4: return "R6";   5: return "R7";   6: return "R6";   7: return "R5";
      8: return "R7";   9: return "R11";  10: return "R5";  11: return "R3";
      12: return "R3";  13: return "R2";  14: return "R2";  15: return "R2";
      22: return "R1";  24: return "R1";  25: return "R1";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic exp_drv, input logic [DW-1:0] exp_d);
    n_run++;
    if (rdrive_o !== exp_drv || rdata_o !== exp_d) begin
      n_fail++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, rdrive_o, rdata_o, exp_drv, exp_d);
    end
  endtask

  task automatic clear_pipe(input string tag);
    p1_drv = 1'b0; p1_data = '0; p1_tag = tag;
    p2_drv = 1'b0; p2_data = '0; p2_tag = tag;
    pend_wr = 1'b0;
  endtask

  task automatic step(input logic slp, input logic seln, input logic wrn,
                      input logic [NL-1:0] ln, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input string tag);
    @(negedge clk);
    check(p2_tag, p2_drv, p2_data);
    // data phase of the previous write (R4)
    if (pend_wr && !slp) begin
      for (int l = 0; l < NL; l++)
        if (pend_mask[l]) flat[pend_addr][l*LW +: LW] = wd[l*LW +: LW];
    end
    pend_wr = 1'b0;
    p2_drv = p1_drv; p2_data = p1_data; p2_tag = p1_tag;
    if (slp) begin p2_drv = 1'b0; p2_data = '0; end
    p1_drv = 1'b0; p1_data = '0; p1_tag = tag;
    if (!slp && !seln) begin
      if (wrn) begin
        p1_drv = 1'b1; p1_data = flat[a];
      end else if (ln != '1) begin
        pend_wr = 1'b1; pend_addr = a; pend_mask = ~ln;
      end
    end
    sleep_i = slp; sel_n_i = seln; wr_n_i = wrn;
    lane_wr_n_i = ln; addr_i = a; wdata_i = wd;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b1, 1'b1, '1, '0, '0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sleep_i = 1'b0; oe_n_i = 1'b0; sel_n_i = 1'b1; wr_n_i = 1'b1;
    lane_wr_n_i = '1; addr_i = '0; wdata_i = '0;
    repeat (2) @(negedge clk);
    check("R10", 1'b0, '0);
    rst_n = 1'b1;
    clear_pipe("R10");
    repeat (3) idle("R10");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] old_a1;
    for (int i = 0; i < (1 << AW); i++) flat[i] = '0;
    clear_pipe("R10");
    do_reset();

    // table walk
    for (int i = 0; i < NV; i++)
      step(VECS[i][48], VECS[i][47], VECS[i][46], VECS[i][45:42],
           VECS[i][41:36], VECS[i][35:0], vec_tag(i));

    // R8 / R9: asynchronous gating inside one cycle
    step(1'b0, 1'b0, 1'b1, '1, 6'd1, '0, "R8");
    idle("R8");
    idle("R8");
    #0.5 oe_n_i = 1'b1;
    #0.3 check("R8", 1'b0, '0);
    oe_n_i = 1'b0;
    #0.3 check("R8", 1'b1, flat[1]);
    sleep_i = 1'b1;
    #0.3 check("R9", 1'b0, '0);
    sleep_i = 1'b0;
    #0.3 check("R9", 1'b1, flat[1]);
    idle("R8");
    idle("R8");

    // R10: reset drops the buffered write; array keeps the older word
    old_a1 = flat[1];
    step(1'b0, 1'b0, 1'b0, 4'b0000, 6'd1, '0, "R10");
    step(1'b0, 1'b1, 1'b1, '1, 6'd0, 36'h0DEADBEEF, "R10");
    idle("R10");
    do_reset();
    flat[1] = old_a1;
    step(1'b0, 1'b0, 1'b1, '1, 6'd1, '0, "R10");
    idle("R10");
    idle("R10");
    idle("R10");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule